// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and century. A one-cycle pulse from an external prescaler, once per second, advances the seconds. Each field that wraps carries into the next one, up to the century. The length of each month comes from the current month and year, and February gains its 29th day in leap years.

A host-side interface, which is not part of this block, sets the time through a parallel load port. Each field has its own enable bit and data byte. A load wins over counting in the same cycle, and the block stores the value exactly as given. A stop flag, kept at bit 7 of the seconds byte, freezes all counting while it is set. Every field is driven straight from a register.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After a synchronous reset the fields read century 20, year 00, month 01, date 01, day 01, hours 00, minutes 00 and seconds 00, and the stop flag is clear.
- R2: Each tick adds one to the seconds with a BCD carry between digits (09 becomes 10). Without a tick or a load, every field holds its value.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and advance both the date and the day of week.
- R4: Day of week counts 01 to 07 and goes from 07 back to 01 at midnight. The date does not affect it.
- R5: Months 04, 06, 09 and 11 roll the date from 30 to 01 and carry into the month. February follows R6. Every other month rolls the date after 31.
- R6: February ends on the 29th when the BCD year is a multiple of four: tens digit even and units 0, 4 or 8, or tens digit odd and units 2 or 6. In every other year it ends on the 28th.
- R7: At 23:59:59 on 12/31 the next tick gives 00:00:00 on 01/01 of the next year. Year 99 goes to 00 and adds one to the century, and century 39 goes to 00.
- R8: When the seconds byte is loaded, its bit 7 sets or clears the stop flag and bits 6:0 become the seconds value. The seconds output shows the flag at bit 7. While the flag is set, ticks change no field.
- R9: Load enable bit i and load data byte i address field i, in this order: 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year, 7 century. A loaded field takes the given value in the next cycle even if a tick arrives in the same cycle. The value gets no range correction, and a field that is being loaded sends no carry onward in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| ld_en_i | input | 8 | Per-field load enables, bit i loads field i |
| ld_val_i | input | 64 | Load data, byte i goes to field i |
| sec_o | output | 8 | Stop flag at bit 7, BCD seconds in bits 6:0 |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, 00-23 |
| day_o | output | 8 | BCD day of week, 01-07 |
| date_o | output | 8 | BCD date, 01-31 |
| month_o | output | 8 | BCD month, 01-12 |
| year_o | output | 8 | BCD year, 00-99 |
| cent_o | output | 8 | BCD century, 00-39 |

## Verification
The bench loads a time just before each month end and checks where the date goes on the next tick. This covers 30-day months, 31-day months, and February in leap and non-leap years such as 00, 10, 12 and 96. A wrong leap decode would show 02/29 in 2010 or jump to 03/01 in 2012, and a wrong month table would give a 31st in November. The year and century roll-overs are tested up to 39/99, where a chain with a missing carry would leave the century unchanged or produce 40. Further tests check that the stop flag freezes all fields, that a load wins over a carry arriving in the same cycle, and that an out-of-range hour is stored as given, since a design that clamped or rewrote loaded values would read back something else.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int FW      = 8;
  localparam int NF      = 8;
  localparam int NDIG    = FW / 4;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DAY   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;
  localparam int F_CENT  = 7;

  // Lowest legal value of each field (wrap target)
  function automatic logic [FW-1:0] field_min(input int f);
    case (f)
      F_DAY, F_DATE, F_MONTH: field_min = 8'h01;
      default:                field_min = 8'h00;
    endcase
  endfunction

  // Fixed upper limit; the date limit is replaced by the month length
  function automatic logic [FW-1:0] field_max(input int f);
    case (f)
      F_SEC, F_MIN: field_max = 8'h59;
      F_HOUR:       field_max = 8'h23;
      F_DAY:        field_max = 8'h07;
      F_DATE:       field_max = 8'h31;
      F_MONTH:      field_max = 8'h12;
      F_YEAR:       field_max = 8'h99;
      default:      field_max = 8'h39;
    endcase
  endfunction

  function automatic logic [FW-1:0] field_rst(input int f);
    case (f)
      F_DAY, F_DATE, F_MONTH: field_rst = 8'h01;
      F_CENT:                 field_rst = 8'h20;
      default:                field_rst = 8'h00;
    endcase
  endfunction

  // Multiple-of-four test on a packed BCD year
  function automatic logic bcd_leap(input logic [FW-1:0] yr);
    logic [3:0] u;
    u = yr[3:0];
    if (yr[4] == 1'b0) bcd_leap = (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    else               bcd_leap = (u == 4'd2) || (u == 4'd6);
  endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [FW-1:0] month_i,
  input  logic [FW-1:0] year_i,
  output logic [FW-1:0] last_o
);
  logic leap;

  always_comb begin
    leap = bcd_leap(year_i);
    case (month_i)
      8'h02:                      last_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

  // R5 R6: the limit is always one of the four legal month ends
  always_comb begin
    month_len_range_chk: assert (last_o == 8'h28 || last_o == 8'h29 ||
                                 last_o == 8'h30 || last_o == 8'h31);
  end
endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
  import cal_pkg::*;
#(
  parameter int            W       = FW,
  parameter logic [W-1:0]  MIN_VAL = '0,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam int ND = W / 4;

  logic [W-1:0] val_q;
  logic [W-1:0] nxt_inc;
  logic         at_max;

  // Digit-wise BCD increment with ripple carry
  always_comb begin
    logic c;
    c       = 1'b1;
    nxt_inc = val_q;
    for (int d = 0; d < ND; d++) begin
      if (c) begin
        if (val_q[4*d +: 4] >= 4'd9) begin
          nxt_inc[4*d +: 4] = 4'd0;
        end else begin
          nxt_inc[4*d +: 4] = val_q[4*d +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
  end

  assign at_max  = (val_q >= max_i);
  assign carry_o = inc_i && !ld_i && at_max;

  always_ff @(posedge clk) begin
    if (rst)        val_q <= RST_VAL;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= at_max ? MIN_VAL : nxt_inc;
  end

  assign val_o = val_q;

  // R9
  ld_prio_chk: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (val_o == $past(ld_val_i)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !inc_i) |=> $stable(val_o));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    carry_o |=> (val_o == MIN_VAL));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !ld_i && !carry_o) |=> !$stable(val_o));
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [NF-1:0]    ld_en_i,
  input  logic [NF*FW-1:0] ld_val_i,
  output logic [FW-1:0]    sec_o,
  output logic [FW-1:0]    min_o,
  output logic [FW-1:0]    hour_o,
  output logic [FW-1:0]    day_o,
  output logic [FW-1:0]    date_o,
  output logic [FW-1:0]    month_o,
  output logic [FW-1:0]    year_o,
  output logic [FW-1:0]    cent_o
);
  logic          stop_q;
  logic [NF-1:0] inc;
  logic [NF-1:0] carry;
  logic [FW-1:0] fval  [NF];
  logic [FW-1:0] fmax  [NF];
  logic [FW-1:0] fload [NF];
  logic [FW-1:0] month_last;

  // Stop flag lives at bit 7 of the seconds byte
  always_ff @(posedge clk) begin
    if (rst)                 stop_q <= 1'b0;
    else if (ld_en_i[F_SEC]) stop_q <= ld_val_i[FW-1];
  end

  cal_month_len u_mlen (
    .month_i (fval[F_MONTH]),
    .year_i  (fval[F_YEAR]),
    .last_o  (month_last)
  );

  // Carry chain; hours feed both day of week and date
  always_comb begin
    inc[F_SEC]   = tick_i && !stop_q;
    inc[F_MIN]   = carry[F_SEC];
    inc[F_HOUR]  = carry[F_MIN];
    inc[F_DAY]   = carry[F_HOUR];
    inc[F_DATE]  = carry[F_HOUR];
    inc[F_MONTH] = carry[F_DATE];
    inc[F_YEAR]  = carry[F_MONTH];
    inc[F_CENT]  = carry[F_YEAR];
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    if (i == F_DATE) begin : g_dyn
      assign fmax[i] = month_last;
    end else begin : g_fix
      assign fmax[i] = field_max(i);
    end
    if (i == F_SEC) begin : g_mask
      assign fload[i] = {1'b0, ld_val_i[i*FW +: FW-1]};
    end else begin : g_full
      assign fload[i] = ld_val_i[i*FW +: FW];
    end
    cal_bcd_field #(
      .W       (FW),
      .MIN_VAL (field_min(i)),
      .RST_VAL (field_rst(i))
    ) u_fld (
      .clk      (clk),
      .rst      (rst),
      .inc_i    (inc[i]),
      .ld_i     (ld_en_i[i]),
      .ld_val_i (fload[i]),
      .max_i    (fmax[i]),
      .val_o    (fval[i]),
      .carry_o  (carry[i])
    );
  end

  assign sec_o   = {stop_q, fval[F_SEC][FW-2:0]};
  assign min_o   = fval[F_MIN];
  assign hour_o  = fval[F_HOUR];
  assign day_o   = fval[F_DAY];
  assign date_o  = fval[F_DATE];
  assign month_o = fval[F_MONTH];
  assign year_o  = fval[F_YEAR];
  assign cent_o  = fval[F_CENT];

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_q && ld_en_i == '0) |=> ($stable(min_o) && $stable(sec_o) &&
                                   $stable(hour_o) && $stable(date_o)));
  // R4
  day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (carry[F_DAY] && !ld_en_i[F_DAY]) |=> (day_o == 8'h01));
  // R3
  midnight_chk: assert property (@(posedge clk) disable iff (rst)
    (carry[F_HOUR] && ld_en_i == '0) |=> (!$stable(day_o) && !$stable(date_o)));
  // R7
  cent_step_chk: assert property (@(posedge clk) disable iff (rst)
    (carry[F_YEAR] && ld_en_i == '0) |=> (!$stable(cent_o) && year_o == 8'h00));
  // R7
  cent_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (carry[F_CENT] && !ld_en_i[F_CENT]) |=> (cent_o == 8'h00));
endmodule

// File: tb/bcd_calendar_clock_bench.sv
`timescale 1ns/1ps
module bcd_calendar_clock_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  ld_en = '0;
  logic [63:0] ld_val = '0;
  logic [7:0]  sec_o, min_o, hour_o, day_o, date_o, month_o, year_o, cent_o;
  logic [63:0] now;
  int          n_chk = 0;
  int          n_err = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock u_bcd_calendar_clock (
    .clk(clk), .rst(rst), .tick_i(tick), .ld_en_i(ld_en), .ld_val_i(ld_val),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o));

  // {century, year, month, date, day, hour, minute, second}
  assign now = {cent_o, year_o, month_o, date_o, day_o, hour_o, min_o, sec_o};

  localparam int NV = 20;
  localparam logic [63:0] VIN [NV] = '{
    64'h20230514_03102009, 64'h20230514_03102059, 64'h20230514_03105959,
    64'h20230514_03235959, 64'h20230514_07235959, 64'h20230430_02235959,
    64'h20230530_02235959, 64'h20230531_02235959, 64'h20231130_05235959,
    64'h20230131_05235959, 64'h20240228_03235959, 64'h20240229_04235959,
    64'h20230228_02235959, 64'h20000228_01235959, 64'h20100228_01235959,
    64'h20120228_01235959, 64'h20960228_01235959, 64'h20231231_06235959,
    64'h20991231_07235959, 64'h39991231_03235959};
  localparam logic [63:0] VEXP [NV] = '{
    64'h20230514_03102010, 64'h20230514_03102100, 64'h20230514_03110000,
    64'h20230515_04000000, 64'h20230515_01000000, 64'h20230501_03000000,
    64'h20230531_03000000, 64'h20230601_03000000, 64'h20231201_06000000,
    64'h20230201_06000000, 64'h20240229_04000000, 64'h20240301_05000000,
    64'h20230301_03000000, 64'h20000229_02000000, 64'h20100301_02000000,
    64'h20120229_02000000, 64'h20960229_02000000, 64'h20240101_07000000,
    64'h21000101_01000000, 64'h00000101_04000000};
  // Requirement per vector: R2, R3 x3, R4, R5 x5, R6 x7, R7 x3
  localparam int VREQ [NV] = '{2, 3, 3, 3, 4, 5, 5, 5, 5, 5,
                               6, 6, 6, 6, 6, 6, 6, 7, 7, 7};

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] en, input logic [63:0] v);
    @(negedge clk);
    ld_en  = en;
    ld_val = v;
    @(negedge clk);
    ld_en  = '0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(1, now, 64'h20000101_01000000);

    // R2 idle cycles leave every field untouched
    repeat (5) @(negedge clk);
    chk(2, now, 64'h20000101_01000000);

    // Vector table: load a full time, tick once, compare
    for (int k = 0; k < NV; k++) begin
      load(8'hFF, VIN[k]);
      one_tick();
      chk(VREQ[k], now, VEXP[k]);
    end

    // R2 R3 sixty-one ticks from midnight
    load(8'hFF, 64'h20230514_03000000);
    for (int t = 0; t < 61; t++) one_tick();
    chk(3, now, 64'h20230514_03000101);

    // R8 stop flag set through seconds bit 7 freezes the clock
    load(8'hFF, 64'h20230514_03102095);
    chk(8, now, 64'h20230514_03102095);
    for (int t = 0; t < 3; t++) one_tick();
    chk(8, now, 64'h20230514_03102095);
    load(8'h01, 64'h00000000_00000015);
    one_tick();
    chk(8, now, 64'h20230514_03102016);

    // R9 minute load beats the carry from seconds in the same cycle
    load(8'hFF, 64'h20230514_03102059);
    @(negedge clk);
    ld_en  = 8'h02;
    ld_val = 64'h00000000_00004200;
    tick   = 1'b1;
    @(negedge clk);
    ld_en = '0;
    tick  = 1'b0;
    chk(9, now, 64'h20230514_03104200);

    // R9 seconds load with tick: value taken, no carry into minutes
    @(negedge clk);
    ld_en  = 8'h01;
    ld_val = 64'h00000000_00000059;
    tick   = 1'b1;
    @(negedge clk);
    ld_en = '0;
    tick  = 1'b0;
    chk(9, now, 64'h20230514_03104259);

    // R9 out-of-range hour is stored unchanged
    load(8'h04, 64'h00000000_00250000);
    chk(9, now, 64'h20230514_03254259);
    one_tick();
    chk(3, now, 64'h20230514_03254300);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule